// File: doc/BRIEF.md
# Dual-Port Byte-Lane RAM

This block is a true dual-port word store with two fully independent ports, called left and right. Each port carries its own address, a 36-bit write bus, a 36-bit read bus and a per-bit drive-enable vector that stands in for a tri-state pad. A port is selected by a pair of chip selects of opposite polarity. A read/write select, an output enable, a sleep input and a semaphore select qualify the access. The word is cut into four 9-bit lanes, and each lane has its own active-low enable, so any mix of lanes can be written or read in a single access.

Both ports may touch the same word in the same cycle. Each port performs at most one access per clock. Read data and its drive-enable vector are registered: they appear on the outputs after the clock edge that sampled the request. When both ports write the same word in the same cycle, the left port takes every lane it writes, and the right port's value lands only in the lanes the left port leaves alone. A read on one port and a write on the other to the same word in the same cycle return the contents from before the write.

Top module: `dpr_lane_ram`

## Requirements
- R1: A port accesses the array only when its `cs_n` is 0 and its `cs` is 1. Any other pair blocks writes, and the next cycle shows `rdata_oe` = 0 and `rdata` = 0.
- R2: Lane k is word bits 9k to 9k+8 (lane 0 = bits 0–8, lane 3 = bits 27–35), and lane k is enabled when bit k of `lane_n` is 0.
- R3: A write (selected, `read` = 0) updates only the enabled lanes of the addressed word. The other lanes keep their contents, and a write with no lane enabled changes nothing.
- R4: A read (selected, `read` = 1, `oe_n` = 0) places the stored value of each enabled lane on `rdata` in the cycle after the request and sets all nine `rdata_oe` bits of that lane. Disabled lanes show 0 on both `rdata` and `rdata_oe`.
- R5: With `oe_n` = 1, a read drives nothing (`rdata_oe` = 0). During a write, `oe_n` has no effect on whether the write happens.
- R6: While `sleep` = 1, the port neither reads nor writes, and its outputs are 0 in the following cycle.
- R7: While `sem_n` = 0, the port neither reads nor writes the array.
- R8: When both ports write the same address in one cycle, each lane takes the left port's data if the left port enables it, and otherwise the right port's data if the right port enables it.
- R9: A read on one port and a write on the other port to the same address in the same cycle return the data stored before that write.
- R10: In the cycle after any request that is not a read, including a write, `rdata_oe` and `rdata` are 0.
- R11: When `rst_n` is 0 at a clock edge, both ports' `rdata` and `rdata_oe` are 0 after that edge. Reset does not clear the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous active-low reset of the output registers |
| l_cs_n | input | 1 | Left select, active low |
| l_cs | input | 1 | Left select, active high |
| l_read | input | 1 | Left direction: 1 read, 0 write |
| l_oe_n | input | 1 | Left read drive enable, active low |
| l_sleep | input | 1 | Left sleep, active high |
| l_sem_n | input | 1 | Left semaphore select, active low (takes the port off the array) |
| l_lane_n | input | 4 | Left lane enables, active low |
| l_addr | input | AW | Left word address |
| l_wdata | input | 36 | Left write data |
| l_rdata | output | 36 | Left read data, 0 in lanes not driven |
| l_rdata_oe | output | 36 | Left per-bit drive enable |
| r_cs_n | input | 1 | Right select, active low |
| r_cs | input | 1 | Right select, active high |
| r_read | input | 1 | Right direction: 1 read, 0 write |
| r_oe_n | input | 1 | Right read drive enable, active low |
| r_sleep | input | 1 | Right sleep, active high |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_lane_n | input | 4 | Right lane enables, active low |
| r_addr | input | AW | Right word address |
| r_wdata | input | 36 | Right write data |
| r_rdata | output | 36 | Right read data, 0 in lanes not driven |
| r_rdata_oe | output | 36 | Right per-bit drive enable |

## Verification
The bench targets four cases:
- Same-address write collisions with overlapping lane sets. A design that let the right port win, or that let one port overwrite whole words, would return the wrong lanes.
- A read racing a write from the other port. A store with write-through forwarding would return the new data instead of the old.
- Every way a port can be taken away from the array: each bad chip-select pair, sleep, the semaphore select and a high output enable. A design that ignored any one of them would either corrupt a word that a later read checks, or drive data when it should not.
- Lane placement and an all-lanes-off write. A design with shuffled or merged lanes, or one that ignored the lane enables, would show data in the wrong bit positions.

// File: rtl/dpr_pkg.sv
// Shared constants and types for the dual-port lane RAM.
// Assumes a word of LANES lanes, each LANE_W bits wide.
package dpr_pkg;
    parameter int LANES  = 4;
    parameter int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [LANES-1:0][LANE_W-1:0] word_t;

    // Decoded request of one port for one cycle.
    typedef struct packed {
        logic             wr;
        logic             rd;
        logic [LANES-1:0] lanes;   // active-high lane enables
    } access_t;
endpackage

// File: rtl/dpr_port_ctrl.sv
// Port control decode: turns the raw pins of one port into a request.
// Assumes all inputs are sampled by the array on the same clock edge.
module dpr_port_ctrl
    import dpr_pkg::*;
(
    input  logic             cs_n,
    input  logic             cs,
    input  logic             read,
    input  logic             oe_n,
    input  logic             sleep,
    input  logic             sem_n,
    input  logic [LANES-1:0] lane_n,
    output access_t          acc
);
    logic selected;

    // Port reaches the array only when awake, off the semaphore unit, and selected.
    always_comb begin
        selected  = !sleep && sem_n && !cs_n && cs;
        acc.wr    = selected && !read;
        acc.rd    = selected && read && !oe_n;
        acc.lanes = ~lane_n;
    end
endmodule

// File: rtl/dpr_lane_array.sv
// Two-port storage with per-lane write masks.
// Assumes one request per port per cycle. Reads return the pre-write contents,
// and when both ports write one lane of the same word, the left port wins.
module dpr_lane_array
    import dpr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic    clk,
    input  logic [AW-1:0] addr_l,
    input  logic [AW-1:0] addr_r,
    input  access_t acc_l,
    input  access_t acc_r,
    input  word_t   wd_l,
    input  word_t   wd_r,
    output word_t   q_l,
    output word_t   q_r
);
    word_t mem [DEPTH];

    // Lane writes. The left update is issued last, so it overrides a same-lane collision.
    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (acc_r.wr && acc_r.lanes[k]) mem[addr_r][k] <= wd_r[k];
            if (acc_l.wr && acc_l.lanes[k]) mem[addr_l][k] <= wd_l[k];
        end
    end

    // Registered reads; nonblocking semantics return the old word.
    always_ff @(posedge clk) begin
        if (acc_l.rd) q_l <= mem[addr_l];
        if (acc_r.rd) q_r <= mem[addr_r];
    end
endmodule

// File: rtl/dpr_read_port.sv
// Read output stage of one port: registers which lanes drive and gates the data.
// Assumes q is captured by the array on the same edge as the lane mask here.
module dpr_read_port
    import dpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  access_t           acc,
    input  word_t             q,
    output logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] rdata_oe
);
    logic [LANES-1:0] drive_q;

    // Remember which lanes the accepted read enabled; clear on reset or non-read.
    always_ff @(posedge clk) begin
        if (!rst_n)      drive_q <= '0;
        else if (acc.rd) drive_q <= acc.lanes;
        else             drive_q <= '0;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign rdata_oe[k*LANE_W +: LANE_W] = {LANE_W{drive_q[k]}};
        assign rdata[k*LANE_W +: LANE_W]    = drive_q[k] ? q[k] : '0;
    end

    // R10: a cycle with no read leaves the port silent next cycle.
    assert_idle_dark_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc.rd |=> (rdata_oe == '0));
    // R4: the driven width matches the lanes requested.
    assert_lane_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc.rd |=> ($countones(rdata_oe) == LANE_W * $countones($past(acc.lanes))));
    // R11: reset silences the port.
    assert_reset_dark_R11: assert property (@(posedge clk)
        !rst_n |=> (rdata_oe == '0 && rdata == '0));
endmodule

// File: rtl/dpr_lane_ram.sv
// Top of the dual-port lane RAM: two control decoders, shared storage, two read stages.
// Assumes both ports share one clock; the array contents are not reset.
module dpr_lane_ram
    import dpr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_cs_n,
    input  logic              l_cs,
    input  logic              l_read,
    input  logic              l_oe_n,
    input  logic              l_sleep,
    input  logic              l_sem_n,
    input  logic [LANES-1:0]  l_lane_n,
    input  logic [AW-1:0]     l_addr,
    input  logic [WORD_W-1:0] l_wdata,
    output logic [WORD_W-1:0] l_rdata,
    output logic [WORD_W-1:0] l_rdata_oe,
    input  logic              r_cs_n,
    input  logic              r_cs,
    input  logic              r_read,
    input  logic              r_oe_n,
    input  logic              r_sleep,
    input  logic              r_sem_n,
    input  logic [LANES-1:0]  r_lane_n,
    input  logic [AW-1:0]     r_addr,
    input  logic [WORD_W-1:0] r_wdata,
    output logic [WORD_W-1:0] r_rdata,
    output logic [WORD_W-1:0] r_rdata_oe
);
    access_t acc_l, acc_r;
    word_t   wd_l, wd_r, q_l, q_r;

    assign wd_l = l_wdata;
    assign wd_r = r_wdata;

    dpr_port_ctrl u_ctrl_l (
        .cs_n(l_cs_n), .cs(l_cs), .read(l_read), .oe_n(l_oe_n),
        .sleep(l_sleep), .sem_n(l_sem_n), .lane_n(l_lane_n), .acc(acc_l)
    );
    dpr_port_ctrl u_ctrl_r (
        .cs_n(r_cs_n), .cs(r_cs), .read(r_read), .oe_n(r_oe_n),
        .sleep(r_sleep), .sem_n(r_sem_n), .lane_n(r_lane_n), .acc(acc_r)
    );

    dpr_lane_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk(clk), .addr_l(l_addr), .addr_r(r_addr), .acc_l(acc_l), .acc_r(acc_r),
        .wd_l(wd_l), .wd_r(wd_r), .q_l(q_l), .q_r(q_r)
    );

    dpr_read_port u_rd_l (
        .clk(clk), .rst_n(rst_n), .acc(acc_l), .q(q_l),
        .rdata(l_rdata), .rdata_oe(l_rdata_oe)
    );
    dpr_read_port u_rd_r (
        .clk(clk), .rst_n(rst_n), .acc(acc_r), .q(q_r),
        .rdata(r_rdata), .rdata_oe(r_rdata_oe)
    );

    // R1: a bad select pair on the left leaves its outputs off next cycle.
    assert_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_cs_n && l_cs) |=> (l_rdata_oe == '0));
    // R5: a right read with the drive enable high drives nothing.
    assert_oe_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_read && r_oe_n) |=> (r_rdata_oe == '0));
    // R6: a sleeping left port stays dark.
    assert_sleep_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
        l_sleep |=> (l_rdata_oe == '0 && l_rdata == '0));
    // R7: a right port on the semaphore unit does not drive array data.
    assert_sem_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !r_sem_n |=> (r_rdata_oe == '0));
endmodule

// File: tb/sim_dpr_lane_ram.sv
`timescale 1ns/1ps
module sim_dpr_lane_ram;
    localparam int AW = 6;

    typedef struct packed {
        logic        csn, cs, rd, oen, slp, semn;
        logic [3:0]  ben;
        logic [5:0]  addr;
        logic [35:0] wd;
    } ps_t;

    typedef struct packed {
        ps_t         l;
        ps_t         r;
        logic [35:0] el;
        logic [3:0]  ml;
        logic [35:0] er;
        logic [3:0]  mr;
        logic [7:0]  req;
    } vec_t;

    localparam logic [35:0] A = 36'hAAAAAAAAA;
    localparam logic [35:0] B = 36'h555555555;
    localparam logic [35:0] C = 36'h123456789;
    localparam logic [35:0] D = 36'hFEDCBA987;

    function automatic logic [35:0] lm(input logic [3:0] en);
        logic [35:0] m;
        m = '0;
        for (int k = 0; k < 4; k++) if (en[k]) m[k*9 +: 9] = 9'h1FF;
        return m;
    endfunction

    function automatic ps_t mk(input logic [5:0] a, input logic [3:0] b, input logic [35:0] d,
                               input logic rd, input logic csn, input logic cs,
                               input logic oen, input logic slp, input logic semn);
        ps_t p;
        p.csn = csn; p.cs = cs; p.rd = rd; p.oen = oen; p.slp = slp; p.semn = semn;
        p.ben = b; p.addr = a; p.wd = d;
        return p;
    endfunction

    function automatic ps_t W(input logic [5:0] a, input logic [3:0] b, input logic [35:0] d);
        return mk(a, b, d, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    endfunction
    function automatic ps_t Rd(input logic [5:0] a, input logic [3:0] b);
        return mk(a, b, 36'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    endfunction
    function automatic ps_t IDLE();
        return mk(6'd0, 4'hF, 36'h0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    endfunction

    localparam logic [35:0] W5 = (B & lm(4'b0101)) | (A & lm(4'b1010));
    localparam logic [35:0] W9 = (C & lm(4'b0011)) | (D & lm(4'b1100));

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{W(5,4'h0,A), IDLE(), 36'h0, 4'h0, 36'h0, 4'h0, 8'd3},          // R3 full write
        '{IDLE(), Rd(5,4'h0), 36'h0, 4'h0, A, 4'hF, 8'd4},               // R4 full read
        '{W(5,4'b1010,B), IDLE(), 36'h0, 4'h0, 36'h0, 4'h0, 8'd3},       // R3 lanes 0,2
        '{Rd(5,4'h0), IDLE(), W5, 4'hF, 36'h0, 4'h0, 8'd3},              // R3 merge kept
        '{IDLE(), Rd(5,4'b1101), 36'h0, 4'h0, W5 & lm(4'b0010), 4'b0010, 8'd4}, // R4 lane 1 only
        '{W(9,4'b1100,C), W(9,4'h0,D), 36'h0, 4'h0, 36'h0, 4'h0, 8'd8},  // R8 collision
        '{Rd(9,4'h0), IDLE(), W9, 4'hF, 36'h0, 4'h0, 8'd8},              // R8 result
        '{W(9,4'h0,A), Rd(9,4'h0), 36'h0, 4'h0, W9, 4'hF, 8'd9},         // R9 old data
        '{IDLE(), Rd(9,4'h0), 36'h0, 4'h0, A, 4'hF, 8'd9},               // R9 new data after
        '{mk(9,4'h0,36'h0,1,0,1,1,0,1), mk(12,4'h0,C,0,0,1,1,0,1),
          36'h0, 4'h0, 36'h0, 4'h0, 8'd5},                                // R5 oe_n high
        '{W(13,4'h0,B), Rd(12,4'h0), 36'h0, 4'h0, C, 4'hF, 8'd5},        // R5 write landed
        '{mk(12,4'h0,D,0,1,1,0,0,1), mk(13,4'h0,D,0,0,0,0,0,1),
          36'h0, 4'h0, 36'h0, 4'h0, 8'd1},                                // R1 bad selects
        '{mk(12,4'h0,36'h0,1,0,1,0,1,1), mk(13,4'h0,36'h0,1,0,1,0,0,0),
          36'h0, 4'h0, 36'h0, 4'h0, 8'd6},                                // R6/R7 reads dark
        '{Rd(12,4'h0), Rd(13,4'h0), C, 4'hF, B, 4'hF, 8'd1},             // R1 writes ignored
        '{mk(12,4'h0,D,0,0,1,0,1,1), mk(13,4'h0,D,0,0,1,0,0,0),
          36'h0, 4'h0, 36'h0, 4'h0, 8'd7},                                // R7/R6 writes
        '{Rd(12,4'h0), Rd(13,4'h0), C, 4'hF, B, 4'hF, 8'd7},             // R7 R6 ignored
        '{W(12,4'hF,D), Rd(12,4'hF), 36'h0, 4'h0, 36'h0, 4'h0, 8'd3},    // R3 no lanes
        '{Rd(12,4'h0), mk(12,4'h0,36'h0,1,1,0,0,0,1), C, 4'hF, 36'h0, 4'h0, 8'd1}, // R1
        '{W(30,4'h0,36'h0), IDLE(), 36'h0, 4'h0, 36'h0, 4'h0, 8'd2},     // R2 clear
        '{W(30,4'b0111,36'hFFFFFFFFF), IDLE(), 36'h0, 4'h0, 36'h0, 4'h0, 8'd2}, // R2 lane 3
        '{Rd(30,4'h0), Rd(30,4'b0111), 36'hFF8000000, 4'hF, 36'hFF8000000, 4'h8, 8'd2} // R2 position
    };

    logic        clk = 1'b0;
    logic        rst_n;
    ps_t         pl, pr;
    logic [35:0] l_rdata, l_rdata_oe, r_rdata, r_rdata_oe;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    dpr_lane_ram #(.DEPTH(64), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(pl.csn), .l_cs(pl.cs), .l_read(pl.rd), .l_oe_n(pl.oen), .l_sleep(pl.slp),
        .l_sem_n(pl.semn), .l_lane_n(pl.ben), .l_addr(pl.addr), .l_wdata(pl.wd),
        .l_rdata(l_rdata), .l_rdata_oe(l_rdata_oe),
        .r_cs_n(pr.csn), .r_cs(pr.cs), .r_read(pr.rd), .r_oe_n(pr.oen), .r_sleep(pr.slp),
        .r_sem_n(pr.semn), .r_lane_n(pr.ben), .r_addr(pr.addr), .r_wdata(pr.wd),
        .r_rdata(r_rdata), .r_rdata_oe(r_rdata_oe)
    );

    task automatic chk(input string what, input int req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        pl = IDLE();
        pr = IDLE();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk("reset left oe", 11, l_rdata_oe, 36'h0);
        chk("reset left data", 11, l_rdata, 36'h0);
        chk("reset right oe", 11, r_rdata_oe, 36'h0);
        chk("reset right data", 11, r_rdata, 36'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            pl = TBL[i].l;
            pr = TBL[i].r;
            step();
            chk($sformatf("vec %0d left data", i), int'(TBL[i].req), l_rdata, TBL[i].el);
            chk($sformatf("vec %0d left oe", i), int'(TBL[i].req), l_rdata_oe, lm(TBL[i].ml));
            chk($sformatf("vec %0d right data", i), int'(TBL[i].req), r_rdata, TBL[i].er);
            chk($sformatf("vec %0d right oe", i), int'(TBL[i].req), r_rdata_oe, lm(TBL[i].mr));
        end

        // R10: a read followed by a write cycle goes dark
        pl = Rd(9, 4'h0);
        step();
        chk("read before write", 10, l_rdata, A);
        pl = W(40, 4'h0, C);
        step();
        chk("write cycle oe", 10, l_rdata_oe, 36'h0);
        chk("write cycle data", 10, l_rdata, 36'h0);

        // R11: reset during reads wins, and array keeps its contents
        pl = Rd(12, 4'h0);
        pr = Rd(9, 4'h0);
        rst_n = 1'b0;
        step();
        chk("mid reset left oe", 11, l_rdata_oe, 36'h0);
        chk("mid reset right data", 11, r_rdata, 36'h0);
        rst_n = 1'b1;
        step();
        chk("after reset left data", 11, l_rdata, C);
        chk("after reset right data", 11, r_rdata, A);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule